// File: doc/BRIEF.md
# Master Abort Response Mapper

This block sits in a bus bridge next to the logic that forwards transactions to a destination bus. When that bus returns a response to a forwarded transaction, the mapper decides what goes back to the source side. It produces the completion flags and read data for non-posted requests, and a single-cycle error pulse on a fatal or non-fatal sideband line for posted writes. The block does no bus sequencing. It only turns a response into completion attributes and error signalling.

A master abort shows up on the response side as the error flag and the non-existent-address flag both set. One configuration bit, the abort mode, picks one of two behaviours. With the bit clear, the abort is hidden: reads return all ones and writes complete normally. With the bit set, the abort is reported as an error: a non-posted request gets a target-abort completion, and a posted write raises the enabled sideband error line. The mode bit is written through a small write port. It is cleared by reset, and warm reset uses the same input. All outputs are registered and appear one cycle after the request is presented.

Top module: `ma_resp_mapper`

## Requirements
- R1: A response counts as a master abort only when `req_err`=1 and `req_nxa`=1. The class encoding is 2'b00 posted write, 2'b01 non-posted read, 2'b10 non-posted write, and 2'b11 is handled as a non-posted write.
- R2: With the mode bit at 0, a master-aborted non-posted read completes with `cpl_err`=0, `cpl_nxa`=0 and `cpl_rdata`=32'hFFFF_FFFF on every byte lane.
- R3: With the mode bit at 0, a master-aborted non-posted write completes with both flags 0 and data 0, and a master-aborted posted write raises no sideband pulse.
- R4: With the mode bit at 1, a master-aborted non-posted request completes as a target abort: `cpl_err`=1, `cpl_nxa`=0, data 0.
- R5: With the mode bit at 1, a master-aborted posted write pulses `fatal_pulse` for one cycle if `fatal_en`=1. Otherwise it pulses `nonfatal_pulse` if `nonfatal_en`=1. The two pulses are never high together.
- R6: With `fatal_en`=0 and `nonfatal_en`=0, a posted master abort in error mode produces no pulse.
- R7: A response with `req_err`=0 completes with both flags 0. Read data passes through and write completions carry data 0. A response with `req_err`=1 and `req_nxa`=0 completes as a target abort (`cpl_err`=1, `cpl_nxa`=0, data 0) in either mode.
- R8: Outputs appear exactly one clock after a cycle with `req_valid`=1. `cpl_valid` is raised only for non-posted classes. A cycle with `req_valid`=0 leaves every output at 0 in the next cycle.
- R9: The mode bit resets to 0 under `rst`. A write takes effect from the following cycle, so a request in the same cycle as the write is judged by the old value.
- R10: While `rst` is high, all outputs are 0 in the following cycle, whatever the request inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also used as warm reset |
| cfg_wr | input | 1 | Write strobe for the abort mode bit |
| cfg_mode_d | input | 1 | New abort mode value (1 = report aborts as errors) |
| fatal_en | input | 1 | Enable for the fatal sideband line |
| nonfatal_en | input | 1 | Enable for the non-fatal sideband line |
| req_valid | input | 1 | A destination-side response is present |
| req_class | input | 2 | Transaction class of the response |
| req_err | input | 1 | Error flag of the response |
| req_nxa | input | 1 | Non-existent-address flag of the response |
| req_rdata | input | 32 | Read data of the response |
| cpl_valid | output | 1 | Completion to the source side is valid |
| cpl_err | output | 1 | Completion error flag |
| cpl_nxa | output | 1 | Completion non-existent-address flag |
| cpl_rdata | output | 32 | Completion read data |
| fatal_pulse | output | 1 | One-cycle fatal sideband error |
| nonfatal_pulse | output | 1 | One-cycle non-fatal sideband error |

## Verification
A write to the mode bit and a master-aborted request can arrive in the same cycle. The bench provokes this by raising `cfg_wr` with a new mode value in the cycle that carries an aborted read. It expects that completion to follow the old mode, and expects the next aborted read, presented without a write, to follow the new one. A warm reset between two aborted requests is judged the same way. Every combination of mode, enables, class and response flags is swept, and the expected completion is computed arithmetically for each one.

// File: rtl/marm_pkg.sv
package marm_pkg;

    typedef enum logic [1:0] {
        CLS_POSTED_WR = 2'b00,
        CLS_NP_READ   = 2'b01,
        CLS_NP_WRITE  = 2'b10,
        CLS_NP_RSVD   = 2'b11
    } txn_cls_e;

    typedef enum logic [1:0] {
        OUT_OK        = 2'b00,
        OUT_TGT_ABORT = 2'b01,
        OUT_MA_HIDE   = 2'b10,
        OUT_MA_ERROR  = 2'b11
    } outcome_e;

    typedef struct packed {
        logic valid;
        logic err;
        logic nxa;
    } cpl_flags_t;

    typedef struct packed {
        logic fatal;
        logic nonfatal;
    } sb_err_t;

    function automatic logic cls_posted(txn_cls_e c);
        return (c == CLS_POSTED_WR);
    endfunction

    function automatic logic cls_read(txn_cls_e c);
        return (c == CLS_NP_READ);
    endfunction

    function automatic logic is_master_abort(logic err, logic nxa);
        return err & nxa;
    endfunction

endpackage

// File: rtl/ma_mode_reg.sv
module ma_mode_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (wr)
            q <= d;
    end
endmodule

// File: rtl/ma_decode.sv
module ma_decode
    import marm_pkg::*;
(
    input  txn_cls_e cls,
    input  logic     err,
    input  logic     nxa,
    input  logic     mode,
    output outcome_e outcome,
    output logic     posted,
    output logic     is_rd
);
    always_comb begin
        posted = cls_posted(cls);
        is_rd  = cls_read(cls);
        if (is_master_abort(err, nxa))
            outcome = mode ? OUT_MA_ERROR : OUT_MA_HIDE;
        else if (err)
            outcome = OUT_TGT_ABORT;
        else
            outcome = OUT_OK;
    end
endmodule

// File: rtl/ma_resp_build.sv
module ma_resp_build
    import marm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              valid,
    input  outcome_e          outcome,
    input  logic              posted,
    input  logic              is_rd,
    input  logic [DATA_W-1:0] rdata,
    input  logic              fatal_en,
    input  logic              nonfatal_en,
    output cpl_flags_t        flags,
    output logic [DATA_W-1:0] data,
    output sb_err_t           sb
);
    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    logic np_valid;

    always_comb begin
        np_valid    = valid & ~posted;
        flags       = '0;
        flags.valid = np_valid;
        data        = '0;
        sb          = '0;
        unique case (outcome)
            OUT_OK: begin
                if (np_valid && is_rd) data = rdata;
            end
            OUT_TGT_ABORT: begin
                flags.err = np_valid;
            end
            OUT_MA_HIDE: begin
                if (np_valid && is_rd) data = ALL_ONES;
            end
            OUT_MA_ERROR: begin
                if (posted) begin
                    sb.fatal    = valid & fatal_en;
                    sb.nonfatal = valid & ~fatal_en & nonfatal_en;
                end else begin
                    flags.err = np_valid;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ma_resp_mapper.sv
module ma_resp_mapper
    import marm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_mode_d,
    input  logic              fatal_en,
    input  logic              nonfatal_en,
    input  logic              req_valid,
    input  logic [1:0]        req_class,
    input  logic              req_err,
    input  logic              req_nxa,
    input  logic [DATA_W-1:0] req_rdata,
    output logic              cpl_valid,
    output logic              cpl_err,
    output logic              cpl_nxa,
    output logic [DATA_W-1:0] cpl_rdata,
    output logic              fatal_pulse,
    output logic              nonfatal_pulse
);
    logic              mode_q;
    outcome_e          outcome;
    logic              posted;
    logic              is_rd;
    cpl_flags_t        flags_d, flags_q;
    logic [DATA_W-1:0] data_d, data_q;
    sb_err_t           sb_d, sb_q;

    ma_mode_reg u_mode (
        .clk (clk),
        .rst (rst),
        .wr  (cfg_wr),
        .d   (cfg_mode_d),
        .q   (mode_q)
    );

    ma_decode u_dec (
        .cls     (txn_cls_e'(req_class)),
        .err     (req_err),
        .nxa     (req_nxa),
        .mode    (mode_q),
        .outcome (outcome),
        .posted  (posted),
        .is_rd   (is_rd)
    );

    ma_resp_build #(.DATA_W(DATA_W)) u_build (
        .valid       (req_valid),
        .outcome     (outcome),
        .posted      (posted),
        .is_rd       (is_rd),
        .rdata       (req_rdata),
        .fatal_en    (fatal_en),
        .nonfatal_en (nonfatal_en),
        .flags       (flags_d),
        .data        (data_d),
        .sb          (sb_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            data_q  <= '0;
            sb_q    <= '0;
        end else begin
            flags_q <= flags_d;
            data_q  <= data_d;
            sb_q    <= sb_d;
        end
    end

    assign cpl_valid      = flags_q.valid;
    assign cpl_err        = flags_q.err;
    assign cpl_nxa        = flags_q.nxa;
    assign cpl_rdata      = data_q;
    assign fatal_pulse    = sb_q.fatal;
    assign nonfatal_pulse = sb_q.nonfatal;
endmodule

// File: rtl/ma_resp_mapper_chk.sv
module ma_resp_mapper_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_q,
    input logic              fatal_en,
    input logic              nonfatal_en,
    input logic              req_valid,
    input logic [1:0]        req_class,
    input logic              req_err,
    input logic              req_nxa,
    input logic [DATA_W-1:0] req_rdata,
    input logic              cpl_valid,
    input logic              cpl_err,
    input logic              cpl_nxa,
    input logic [DATA_W-1:0] cpl_rdata,
    input logic              fatal_pulse,
    input logic              nonfatal_pulse
);
    logic ma_in, np_in;
    assign ma_in = req_valid && req_err && req_nxa;
    assign np_in = req_class != 2'b00;

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fatal_pulse, nonfatal_pulse})); // R5

    AST_HIDE_READ: assert property (@(posedge clk) disable iff (rst)
        (ma_in && req_class == 2'b01 && !mode_q)
        |=> (cpl_valid && !cpl_err && !cpl_nxa && cpl_rdata == {DATA_W{1'b1}})); // R2

    AST_NP_TGT_ABORT: assert property (@(posedge clk) disable iff (rst)
        (ma_in && np_in && mode_q) |=> (cpl_valid && cpl_err && !cpl_nxa)); // R4

    AST_POSTED_FATAL: assert property (@(posedge clk) disable iff (rst)
        (ma_in && !np_in && mode_q && fatal_en) |=> (fatal_pulse && !cpl_valid)); // R5

    AST_NO_PULSE_DIS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !fatal_en && !nonfatal_en) |=> (!fatal_pulse && !nonfatal_pulse)); // R6

    AST_PASS_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_class == 2'b01 && !req_err)
        |=> (!cpl_err && !cpl_nxa && cpl_rdata == $past(req_rdata))); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!cpl_valid && !fatal_pulse && !nonfatal_pulse)); // R8

    AST_MODE_CLEARED: assert property (@(posedge clk)
        rst |=> !mode_q); // R9

    AST_RESET_OUT: assert property (@(posedge clk)
        rst |=> (!cpl_valid && !fatal_pulse && !nonfatal_pulse)); // R10
endmodule

bind ma_resp_mapper ma_resp_mapper_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .mode_q         (mode_q),
    .fatal_en       (fatal_en),
    .nonfatal_en    (nonfatal_en),
    .req_valid      (req_valid),
    .req_class      (req_class),
    .req_err        (req_err),
    .req_nxa        (req_nxa),
    .req_rdata      (req_rdata),
    .cpl_valid      (cpl_valid),
    .cpl_err        (cpl_err),
    .cpl_nxa        (cpl_nxa),
    .cpl_rdata      (cpl_rdata),
    .fatal_pulse    (fatal_pulse),
    .nonfatal_pulse (nonfatal_pulse)
);

// File: tb/ma_resp_mapper_test.sv
`timescale 1ns/1ps
module ma_resp_mapper_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr, cfg_mode_d, fatal_en, nonfatal_en;
    logic        req_valid, req_err, req_nxa;
    logic [1:0]  req_class;
    logic [31:0] req_rdata;
    logic        cpl_valid, cpl_err, cpl_nxa, fatal_pulse, nonfatal_pulse;
    logic [31:0] cpl_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ma_resp_mapper uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode_d(cfg_mode_d),
        .fatal_en(fatal_en), .nonfatal_en(nonfatal_en),
        .req_valid(req_valid), .req_class(req_class), .req_err(req_err),
        .req_nxa(req_nxa), .req_rdata(req_rdata),
        .cpl_valid(cpl_valid), .cpl_err(cpl_err), .cpl_nxa(cpl_nxa),
        .cpl_rdata(cpl_rdata), .fatal_pulse(fatal_pulse),
        .nonfatal_pulse(nonfatal_pulse)
    );

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cfg_wr = 0; cfg_mode_d = 0; req_valid = 0;
        req_class = 2'b00; req_err = 0; req_nxa = 0; req_rdata = '0;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        cfg_wr = 1; cfg_mode_d = m;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    // drive one request at a negedge, sample the registered result at the next negedge
    task automatic present(input logic [1:0] cls, input logic e, input logic n,
                           input logic [31:0] d);
        req_valid = 1; req_class = cls; req_err = e; req_nxa = n; req_rdata = d;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic expect_out(input string rq, input logic v, input logic e,
                              input logic n, input logic [31:0] d,
                              input logic f, input logic nf);
        check(rq, "cpl_valid", {31'b0, cpl_valid}, {31'b0, v});
        check(rq, "cpl_err",   {31'b0, cpl_err},   {31'b0, e});
        check(rq, "cpl_nxa",   {31'b0, cpl_nxa},   {31'b0, n});
        check(rq, "cpl_rdata", cpl_rdata, d);
        check(rq, "fatal",     {31'b0, fatal_pulse},    {31'b0, f});
        check(rq, "nonfatal",  {31'b0, nonfatal_pulse}, {31'b0, nf});
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        fatal_en = 0; nonfatal_en = 0;
        rst = 1;
        // R10: request presented during reset must not reach the outputs
        @(negedge clk);
        req_valid = 1; req_class = 2'b00; req_err = 1; req_nxa = 1;
        fatal_en = 1; cfg_wr = 1; cfg_mode_d = 1;
        @(negedge clk);
        expect_out("R10", 0, 0, 0, 32'h0, 0, 0);
        idle_inputs();
        fatal_en = 0;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        expect_out("R10", 0, 0, 0, 32'h0, 0, 0);

        // R9: mode was written during reset, so it must still read as 0 (aborted read hidden)
        present(2'b01, 1, 1, 32'h0BAD_0BAD);
        expect_out("R9", 1, 0, 0, 32'hFFFF_FFFF, 0, 0);

        // full sweep: R1..R8
        for (int m = 0; m < 2; m++) begin
            set_mode(m[0]);
            for (int en = 0; en < 4; en++) begin
                for (int c = 0; c < 4; c++) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [31:0] d, ed;
                        logic e, n, pst, rd, ab, ta, ev, ee, ef, enf;
                        string rq;
                        fatal_en    = en[1];
                        nonfatal_en = en[0];
                        e = k[1]; n = k[0];
                        d = 32'h1357_9BDF ^ (32'(m*64 + en*16 + c*4 + k) * 32'h9E37_79B9);
                        pst = (c == 0);
                        rd  = (c == 1);
                        ab  = e & n;
                        ta  = e & ~n;
                        ev = ~pst; ee = 0; ed = 32'h0; ef = 0; enf = 0;
                        if (ab) begin
                            if (m == 1) begin
                                if (pst) begin
                                    ef  = en[1];
                                    enf = ~en[1] & en[0];
                                    rq  = (en == 0) ? "R6" : "R5";
                                end else begin
                                    ee = 1;
                                    rq = "R4";
                                end
                            end else begin
                                if (rd) begin
                                    ed = 32'hFFFF_FFFF;
                                    rq = "R2";
                                end else rq = "R3";
                            end
                        end else if (ta) begin
                            ee = ~pst;
                            rq = "R7";
                        end else begin
                            if (rd) ed = d;
                            rq = (k == 1) ? "R1" : "R7";
                        end
                        present(c[1:0], e, n, d);
                        expect_out(rq, ev, ee, 0, ed, ef, enf);
                        // R8: one cycle later, with no request, everything is quiet
                        @(negedge clk);
                        expect_out("R8", 0, 0, 0, 32'h0, 0, 0);
                    end
                end
            end
        end

        // R9: mode write in the same cycle as an aborted read uses the old value
        fatal_en = 1; nonfatal_en = 0;
        set_mode(0);
        cfg_wr = 1; cfg_mode_d = 1;
        present(2'b01, 1, 1, 32'h2468_ACE0);
        cfg_wr = 0;
        expect_out("R9", 1, 0, 0, 32'hFFFF_FFFF, 0, 0);
        present(2'b01, 1, 1, 32'h2468_ACE0);
        expect_out("R9", 1, 1, 0, 32'h0, 0, 0);

        // R5: back-to-back posted aborts give a pulse in each cycle
        req_valid = 1; req_class = 2'b00; req_err = 1; req_nxa = 1;
        @(negedge clk);
        expect_out("R5", 0, 0, 0, 32'h0, 1, 0);
        @(negedge clk);
        req_valid = 0;
        expect_out("R5", 0, 0, 0, 32'h0, 1, 0);
        @(negedge clk);
        expect_out("R5", 0, 0, 0, 32'h0, 0, 0);

        // R9: warm reset clears the mode bit
        rst = 1;
        @(negedge clk);
        rst = 0;
        present(2'b10, 1, 1, 32'h0);
        expect_out("R9", 1, 0, 0, 32'h0, 0, 0);
        present(2'b00, 1, 1, 32'h0);
        expect_out("R3", 0, 0, 0, 32'h0, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule